// File: doc/BRIEF.md
# Virtual Wire State Tunnel

This block is the host end of a virtual wire channel on a serial link between a host and a target device. It holds a bank of single-bit sideband signals. The host drives some of them and the target drives the rest. It turns the wire states into parallel group beats, and turns group beats back into wire states. Each wire is cleared by one of three reset inputs: link reset, platform reset or deep-sleep power-good reset. A reset of one domain therefore leaves the wires of the other domains alone.

Received packets arrive as a header beat that carries the group count, followed by that many two-byte groups. Interrupt groups are not stored. Each one is turned into a single event on the interrupt port, with the line number and its new level. Wire groups update the target-driven wires. Host-driven wires that change are marked pending. On request, the block emits an outgoing packet that reports every pending wire.

Top module: `vw_tunnel`

## Requirements
- R1: A header beat (rx_sop=1, count in rx_data[7:0]) whose count exceeds cfg_max_groups causes the whole packet to be dropped: no wire changes and no interrupt events. rx_err rises one cycle after that header and stays high until link reset.
- R2: A group whose index is 3, 4 or 5 (wire group g = index-2) updates only those target-driven wires whose valid bit rx_data[4+b] is set. Such a wire, wire_state[4g+b], takes the value of rx_data[b] two cycles after the beat.
- R3: Group bits aimed at host-driven wires (index 2 and bits 12..15 of index 5), and groups with an index of 6 or above, change no wire_state bit.
- R4: A group with index 0 or 1 produces exactly one irq_valid pulse two cycles after its beat, with irq_line = {index[0], rx_data[6:0]} and irq_level = rx_data[7]. Repeated identical groups each produce their own event, so level-style and edge-style sources pass through unchanged.
- R5: A packet whose count equals cfg_max_groups is accepted, and all of its groups take effect.
- R6: While link_rst is high, wire_state[7:0] reads 0 and rx_err reads 0. Bits 8..15 keep their values.
- R7: While plat_rst is high, wire_state[11:8] and wire_state[15] read 0. All other bits keep their values.
- R8: While dsw_rst is high, wire_state[14:12] read 0. All other bits keep their values.
- R9: Host-driven wires (bits 0..3, 12..15) follow host_wire_in one cycle later, and any change marks the wire pending. A tx_start pulse then emits one beat per group that has pending wires, in ascending index order. Each beat is tx_data = {index, pending mask, current 4 states}, and tx_last is set on the final beat only.
- R10: Once reported, pending wires clear. A tx_start with nothing pending emits no beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| link_rst | input | 1 | Synchronous link reset, active high |
| plat_rst | input | 1 | Synchronous platform reset, active high |
| dsw_rst | input | 1 | Synchronous deep-sleep power-good reset, active high |
| cfg_max_groups | input | 8 | Largest group count accepted per packet |
| rx_valid | input | 1 | Receive beat valid |
| rx_sop | input | 1 | Beat is a packet header |
| rx_data | input | 16 | Header count, or group {index, mask, state} |
| host_wire_in | input | 16 | Host-side values for the host-driven wires |
| tx_start | input | 1 | Request an outgoing packet of pending wires |
| tx_valid | output | 1 | Outgoing group beat valid |
| tx_data | output | 16 | Outgoing group {index, mask, state} |
| tx_last | output | 1 | Final beat of the outgoing packet |
| wire_state | output | 16 | Current state of all wires |
| irq_valid | output | 1 | Interrupt event valid |
| irq_line | output | 8 | Interrupt line number |
| irq_level | output | 1 | New interrupt line level |
| rx_err | output | 1 | Sticky oversize-packet flag |

## Verification
rx_err settles on the first rising edge after the header. Wire changes and interrupt events appear on the second rising edge after their group beat, because the parser and the bank each add one register. Outgoing beats start one edge after tx_start and advance one group index per edge. The bench drives inputs on falling edges and waits at least two rising edges before it samples a level at a falling edge. A falling-edge monitor records every irq and tx beat, and the checks compare those logs against the expected counts and values. The reset checks sample while each reset is held high, and again after release.

// File: rtl/vw_pkg.sv
package vw_pkg;
  typedef enum logic [1:0] {
    DOM_LINK = 2'd0,
    DOM_PLAT = 2'd1,
    DOM_DSW  = 2'd2
  } vw_dom_e;

  typedef struct packed {
    logic [7:0] idx;
    logic [7:0] body;
  } vw_group_t;

  localparam int WIRES_PER_GROUP = 4;
endpackage

// File: rtl/vw_rx_parser.sv
module vw_rx_parser
  import vw_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             link_rst,
  input  logic             rx_valid,
  input  logic             rx_sop,
  input  logic [15:0]      rx_data,
  input  logic [CNT_W-1:0] cfg_max,
  output vw_group_t        grp_q,
  output logic             grp_valid_q,
  output logic             err_q
);
  logic [CNT_W-1:0] remain_q;
  logic [CNT_W-1:0] hdr_cnt;

  assign hdr_cnt = rx_data[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (link_rst) begin
      remain_q    <= '0;
      grp_valid_q <= 1'b0;
      grp_q       <= '0;
      err_q       <= 1'b0;
    end else begin
      grp_valid_q <= 1'b0;
      if (rx_valid && rx_sop) begin
        if (hdr_cnt > cfg_max) begin
          err_q    <= 1'b1;
          remain_q <= '0;
        end else begin
          remain_q <= hdr_cnt;
        end
      end else if (rx_valid && remain_q != '0) begin
        grp_valid_q <= 1'b1;
        grp_q       <= rx_data;
        remain_q    <= remain_q - 1'b1;
      end
    end
  end

  // R1: the error flag never drops without link reset
  assert_err_sticky_R1: assert property (@(posedge clk) disable iff (link_rst)
    err_q |=> err_q);

  // R1: the error flag only rises right after a header beat
  assert_err_cause_R1: assert property (@(posedge clk) disable iff (link_rst)
    $rose(err_q) |-> $past(rx_valid && rx_sop));

  // R5: a group is only issued while the accepted packet still has groups left
  assert_grp_bounded_R5: assert property (@(posedge clk) disable iff (link_rst)
    grp_valid_q |-> $past(remain_q) != '0);
endmodule

// File: rtl/vw_irq_fwd.sv
module vw_irq_fwd
  import vw_pkg::*;
#(
  parameter int WIRE_BASE = 2
) (
  input  logic       clk,
  input  logic       link_rst,
  input  logic       grp_valid,
  input  vw_group_t  grp,
  output logic       irq_valid_q,
  output logic [7:0] irq_line_q,
  output logic       irq_level_q
);
  always_ff @(posedge clk) begin
    if (link_rst) begin
      irq_valid_q <= 1'b0;
      irq_line_q  <= '0;
      irq_level_q <= 1'b0;
    end else begin
      irq_valid_q <= grp_valid && (grp.idx < 8'(WIRE_BASE));
      irq_line_q  <= {grp.idx[0], grp.body[6:0]};
      irq_level_q <= grp.body[7];
    end
  end

  // R4: every interrupt event is caused by a group issued one cycle earlier
  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (link_rst)
    irq_valid_q |-> $past(grp_valid));
endmodule

// File: rtl/vw_wire_bank.sv
module vw_wire_bank
  import vw_pkg::*;
#(
  parameter int NG        = 4,
  parameter int WIRE_BASE = 2,
  parameter int NW        = NG * WIRES_PER_GROUP,
  parameter logic [NW-1:0]   DIR_MAP = 16'hF00F,
  parameter logic [2*NW-1:0] DOM_MAP = 32'h6A55_0000
) (
  input  logic          clk,
  input  logic          link_rst,
  input  logic          plat_rst,
  input  logic          dsw_rst,
  input  logic          grp_valid,
  input  vw_group_t     grp,
  input  logic [NW-1:0] host_wire_in,
  input  logic [NW-1:0] clr_mask,
  output logic [NW-1:0] wire_q,
  output logic [NW-1:0] pend_q
);
  logic unused_host_in;
  assign unused_host_in = ^(host_wire_in & ~DIR_MAP);

  for (genvar i = 0; i < NW; i++) begin : g_wire
    localparam logic [1:0] DOM  = DOM_MAP[2*i +: 2];
    localparam int         GRP  = i / WIRES_PER_GROUP;
    localparam int         BIT  = i % WIRES_PER_GROUP;
    logic rst_i;

    if (DOM == DOM_PLAT) begin : g_plat
      assign rst_i = plat_rst;
    end else if (DOM == DOM_DSW) begin : g_dsw
      assign rst_i = dsw_rst;
    end else begin : g_link
      assign rst_i = link_rst;
    end

    if (DIR_MAP[i]) begin : g_out
      always_ff @(posedge clk) begin
        if (rst_i) begin
          wire_q[i] <= 1'b0;
          pend_q[i] <= 1'b0;
        end else begin
          wire_q[i] <= host_wire_in[i];
          pend_q[i] <= (pend_q[i] & ~clr_mask[i]) | (host_wire_in[i] ^ wire_q[i]);
        end
      end
    end else begin : g_in
      logic hit;
      assign hit = grp_valid && (grp.idx == 8'(WIRE_BASE + GRP))
                   && grp.body[WIRES_PER_GROUP + BIT];
      always_ff @(posedge clk) begin
        if (rst_i) begin
          wire_q[i] <= 1'b0;
        end else if (hit) begin
          wire_q[i] <= grp.body[BIT];
        end
      end
      assign pend_q[i] = 1'b0;
    end
  end

  // R2: target-driven wires hold still unless a group or a reset came in
  assert_in_stable_R2: assert property (@(posedge clk) disable iff (link_rst)
    (!$past(link_rst) && !$past(plat_rst) && !$past(dsw_rst) && !$past(grp_valid))
    |-> ((wire_q & ~DIR_MAP) == ($past(wire_q) & ~DIR_MAP)));
endmodule

// File: rtl/vw_tx_builder.sv
module vw_tx_builder
  import vw_pkg::*;
#(
  parameter int NG        = 4,
  parameter int WIRE_BASE = 2,
  parameter int NW        = NG * WIRES_PER_GROUP
) (
  input  logic          clk,
  input  logic          link_rst,
  input  logic          tx_start,
  input  logic [NW-1:0] wire_q,
  input  logic [NW-1:0] pend_q,
  output logic [NW-1:0] clr_mask,
  output logic          tx_valid_q,
  output logic [15:0]   tx_data_q,
  output logic          tx_last_q
);
  localparam int PW = (NG > 1) ? $clog2(NG) : 1;

  logic          busy_q;
  logic [NW-1:0] snap_q;
  logic [PW-1:0] ptr_q;
  logic [3:0]    cur_m;
  logic [3:0]    cur_st;
  logic [NW-1:0] hi_bits;

  always_comb begin
    cur_m    = snap_q[WIRES_PER_GROUP*ptr_q +: WIRES_PER_GROUP];
    cur_st   = wire_q[WIRES_PER_GROUP*ptr_q +: WIRES_PER_GROUP];
    hi_bits  = snap_q >> (WIRES_PER_GROUP * (int'(ptr_q) + 1));
    clr_mask = '0;
    if (busy_q) clr_mask[WIRES_PER_GROUP*ptr_q +: WIRES_PER_GROUP] = cur_m;
  end

  always_ff @(posedge clk) begin
    if (link_rst) begin
      busy_q     <= 1'b0;
      snap_q     <= '0;
      ptr_q      <= '0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
      tx_last_q  <= 1'b0;
    end else begin
      tx_valid_q <= 1'b0;
      tx_last_q  <= 1'b0;
      if (busy_q) begin
        if (cur_m != '0) begin
          tx_valid_q <= 1'b1;
          tx_data_q  <= {8'(WIRE_BASE + int'(ptr_q)), cur_m, cur_st};
          tx_last_q  <= (hi_bits == '0);
        end
        snap_q[WIRES_PER_GROUP*ptr_q +: WIRES_PER_GROUP] <= '0;
        ptr_q <= ptr_q + 1'b1;
        if (hi_bits == '0) busy_q <= 1'b0;
      end else if (tx_start && pend_q != '0) begin
        busy_q <= 1'b1;
        snap_q <= pend_q;
        ptr_q  <= '0;
      end
    end
  end

  // R9: an outgoing beat always reports at least one pending wire
  assert_mask_nonzero_R9: assert property (@(posedge clk) disable iff (link_rst)
    tx_valid_q |-> tx_data_q[7:4] != 4'd0);

  // R10: nothing follows the last beat in the very next cycle
  assert_last_ends_R10: assert property (@(posedge clk) disable iff (link_rst)
    tx_last_q |=> !tx_valid_q);
endmodule

// File: rtl/vw_tunnel.sv
module vw_tunnel
  import vw_pkg::*;
#(
  parameter int NG        = 4,
  parameter int WIRE_BASE = 2,
  parameter int CNT_W     = 8,
  parameter int NW        = NG * WIRES_PER_GROUP,
  parameter logic [NW-1:0]   DIR_MAP = 16'hF00F,
  parameter logic [2*NW-1:0] DOM_MAP = 32'h6A55_0000
) (
  input  logic             clk,
  input  logic             link_rst,
  input  logic             plat_rst,
  input  logic             dsw_rst,
  input  logic [CNT_W-1:0] cfg_max_groups,
  input  logic             rx_valid,
  input  logic             rx_sop,
  input  logic [15:0]      rx_data,
  input  logic [NW-1:0]    host_wire_in,
  input  logic             tx_start,
  output logic             tx_valid,
  output logic [15:0]      tx_data,
  output logic             tx_last,
  output logic [NW-1:0]    wire_state,
  output logic             irq_valid,
  output logic [7:0]       irq_line,
  output logic             irq_level,
  output logic             rx_err
);
  vw_group_t     grp;
  logic          grp_valid;
  logic [NW-1:0] pend;
  logic [NW-1:0] clr_mask;

  vw_rx_parser #(.CNT_W(CNT_W)) u_parser (
    .clk        (clk),
    .link_rst   (link_rst),
    .rx_valid   (rx_valid),
    .rx_sop     (rx_sop),
    .rx_data    (rx_data),
    .cfg_max    (cfg_max_groups),
    .grp_q      (grp),
    .grp_valid_q(grp_valid),
    .err_q      (rx_err)
  );

  vw_irq_fwd #(.WIRE_BASE(WIRE_BASE)) u_irq (
    .clk        (clk),
    .link_rst   (link_rst),
    .grp_valid  (grp_valid),
    .grp        (grp),
    .irq_valid_q(irq_valid),
    .irq_line_q (irq_line),
    .irq_level_q(irq_level)
  );

  vw_wire_bank #(
    .NG(NG), .WIRE_BASE(WIRE_BASE), .NW(NW),
    .DIR_MAP(DIR_MAP), .DOM_MAP(DOM_MAP)
  ) u_bank (
    .clk         (clk),
    .link_rst    (link_rst),
    .plat_rst    (plat_rst),
    .dsw_rst     (dsw_rst),
    .grp_valid   (grp_valid),
    .grp         (grp),
    .host_wire_in(host_wire_in),
    .clr_mask    (clr_mask),
    .wire_q      (wire_state),
    .pend_q      (pend)
  );

  vw_tx_builder #(.NG(NG), .WIRE_BASE(WIRE_BASE), .NW(NW)) u_tx (
    .clk       (clk),
    .link_rst  (link_rst),
    .tx_start  (tx_start),
    .wire_q    (wire_state),
    .pend_q    (pend),
    .clr_mask  (clr_mask),
    .tx_valid_q(tx_valid),
    .tx_data_q (tx_data),
    .tx_last_q (tx_last)
  );
endmodule

// File: tb/vw_tunnel_bench.sv
`timescale 1ns/1ps
module vw_tunnel_bench;
  logic        clk = 1'b0;
  logic        link_rst = 1'b1, plat_rst = 1'b1, dsw_rst = 1'b1;
  logic [7:0]  cfg_max_groups = 8'd4;
  logic        rx_valid = 1'b0, rx_sop = 1'b0;
  logic [15:0] rx_data = '0;
  logic [15:0] host_wire_in = '0;
  logic        tx_start = 1'b0;
  logic        tx_valid, tx_last, irq_valid, irq_level, rx_err;
  logic [15:0] tx_data, wire_state;
  logic [7:0]  irq_line;

  int checks = 0;
  int errors = 0;

  logic [15:0] tx_log   [0:31];
  logic        last_log [0:31];
  logic [8:0]  irq_log  [0:31];
  int tx_n = 0;
  int irq_n = 0;

  always #2 clk = ~clk;

  vw_tunnel u_vw_tunnel (
    .clk(clk), .link_rst(link_rst), .plat_rst(plat_rst), .dsw_rst(dsw_rst),
    .cfg_max_groups(cfg_max_groups), .rx_valid(rx_valid), .rx_sop(rx_sop),
    .rx_data(rx_data), .host_wire_in(host_wire_in), .tx_start(tx_start),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .wire_state(wire_state), .irq_valid(irq_valid), .irq_line(irq_line),
    .irq_level(irq_level), .rx_err(rx_err)
  );

  always @(negedge clk) begin
    if (tx_valid && tx_n < 32) begin
      tx_log[tx_n]   = tx_data;
      last_log[tx_n] = tx_last;
      tx_n++;
    end
    if (irq_valid && irq_n < 32) begin
      irq_log[irq_n] = {irq_level, irq_line};
      irq_n++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_pkt(input int cnt, input int n, input logic [63:0] gs);
    @(negedge clk);
    rx_valid = 1'b1; rx_sop = 1'b1; rx_data = 16'(cnt);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_sop = 1'b0; rx_data = gs[16*k +: 16];
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sop = 1'b0; rx_data = '0;
    cycles(4);
  endtask

  task automatic pulse_tx();
    @(negedge clk); tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
    cycles(10);
  endtask

  task automatic t_reset();
    chk("R6 reset wires", 32'(wire_state), 32'h0);
    chk("R6 reset err", 32'(rx_err), 32'h0);
    chk("R10 reset tx", 32'(tx_valid), 32'h0);
    chk("R4 reset irq", 32'(irq_valid), 32'h0);
  endtask

  task automatic t_input_update();
    cfg_max_groups = 8'd4;
    send_pkt(2, 2, {32'h0, 16'h043A, 16'h03F5});
    chk("R2 grp3 full mask", 32'(wire_state[7:4]), 32'h5);
    chk("R2 grp4 partial mask", 32'(wire_state[11:8]), 32'h2);
    send_pkt(1, 1, {48'h0, 16'h0340});
    chk("R2 single valid bit", 32'(wire_state), 32'h0210);
  endtask

  task automatic t_ignore();
    send_pkt(2, 2, {32'h0, 16'h09FF, 16'h02FF});
    chk("R3 output and unknown groups", 32'(wire_state), 32'h0210);
  endtask

  task automatic t_irq();
    int base;
    base = irq_n;
    send_pkt(3, 3, {16'h0, 16'h0085, 16'h0105, 16'h0085});
    chk("R4 event count", 32'(irq_n - base), 32'd3);
    chk("R4 event0", 32'(irq_log[base]), 32'h105);
    chk("R4 event1", 32'(irq_log[base+1]), 32'h085);
    chk("R4 repeated event2", 32'(irq_log[base+2]), 32'h105);
    chk("R4 no wire change", 32'(wire_state), 32'h0210);
  endtask

  task automatic t_max();
    int base;
    cfg_max_groups = 8'd2;
    base = irq_n;
    send_pkt(2, 2, {32'h0, 16'h0081, 16'h03F0});
    chk("R5 count at max wires", 32'(wire_state), 32'h0200);
    chk("R5 count at max irq", 32'(irq_n - base), 32'd1);
    chk("R5 no error", 32'(rx_err), 32'h0);
    base = irq_n;
    send_pkt(3, 3, {16'h0, 16'h04F0, 16'h0082, 16'h03FF});
    chk("R1 oversize dropped wires", 32'(wire_state), 32'h0200);
    chk("R1 oversize dropped irq", 32'(irq_n - base), 32'd0);
    chk("R1 error raised", 32'(rx_err), 32'h1);
    send_pkt(1, 1, {48'h0, 16'h03FF});
    chk("R1 later packet accepted", 32'(wire_state), 32'h02F0);
    chk("R1 error sticky", 32'(rx_err), 32'h1);
  endtask

  task automatic t_plat();
    host_wire_in = 16'h9000;
    cycles(2);
    chk("R9 host wires followed", 32'(wire_state), 32'h92F0);
    plat_rst = 1'b1;
    cycles(2);
    chk("R7 plat domain cleared", 32'(wire_state), 32'h10F0);
    plat_rst = 1'b0;
    cycles(2);
    chk("R7 after release", 32'(wire_state), 32'h90F0);
  endtask

  task automatic t_dsw();
    send_pkt(1, 1, {48'h0, 16'h04F5});
    chk("R2 grp4 reload", 32'(wire_state), 32'h95F0);
    dsw_rst = 1'b1;
    cycles(2);
    chk("R8 dsw domain cleared", 32'(wire_state), 32'h85F0);
    dsw_rst = 1'b0;
    cycles(2);
    chk("R8 after release", 32'(wire_state), 32'h95F0);
  endtask

  task automatic t_link();
    link_rst = 1'b1;
    cycles(2);
    chk("R6 link domain cleared", 32'(wire_state), 32'h9500);
    chk("R6 err cleared", 32'(rx_err), 32'h0);
    link_rst = 1'b0;
    cycles(2);
    chk("R6 after release", 32'(wire_state), 32'h9500);
  endtask

  task automatic t_tx();
    int base;
    pulse_tx();
    base = tx_n;
    host_wire_in = 16'hB002;
    cycles(2);
    pulse_tx();
    chk("R9 beat count", 32'(tx_n - base), 32'd2);
    chk("R9 beat0 data", 32'(tx_log[base]), 32'h0222);
    chk("R9 beat0 not last", 32'(last_log[base]), 32'h0);
    chk("R9 beat1 data", 32'(tx_log[base+1]), 32'h052B);
    chk("R9 beat1 last", 32'(last_log[base+1]), 32'h1);
    base = tx_n;
    pulse_tx();
    chk("R10 nothing pending", 32'(tx_n - base), 32'd0);
  endtask

  initial begin
    cycles(3);
    link_rst = 1'b0; plat_rst = 1'b0; dsw_rst = 1'b0;
    cycles(2);
    t_reset();
    t_input_update();
    t_ignore();
    t_irq();
    t_max();
    t_plat();
    t_dsw();
    t_link();
    t_tx();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule